// File: doc/BRIEF.md
# Microcoded Bus Bridge Controller

This block joins a 16-bit internal ALU bus to an 8-bit memory data bus under microcode control. Each cycle a microcode word is latched at the rising clock edge. From that latched word the block selects one of five bridge modes: either half of the ALU bus copied onto the data bus, the data bus copied into either half of the ALU bus, or the two buses left apart. The disconnected mode is the one used for register-to-register transfers.

The same word also decides three things. The first is which address register drives the address bus: the program counter when the microcode passes it through to the ALU, otherwise the memory address register. The second is whether the code or the data segment is selected. The third is whether the active-low memory enable is asserted. A decoder for memory-mapped peripherals turns addresses in a configurable 256-byte page into one-hot chip selects. It only works in the data segment while the memory is enabled.

The idle word, with every field at zero, selects the code segment. Because of this, the implicit reads that fill register-to-register and halt cycles cannot touch a read-sensitive peripheral left addressed by the memory address register.

Top module: `bridge_ctl_top`

## Requirements
- R1: While reset is asserted (rstN low), the outputs show the idle word. Mode disconnected, all bus drive enables low, data and ALU bus outputs zero, addrBus equal to marVal, segData 0 (code), memEnN 0, devSel all zero.
- R2: Mode 1 drives dataBusOut with aluBusIn[7:0] and mode 2 drives it with aluBusIn[15:8]. In both, dataDrvEn is 1 and both ALU drive enables are 0.
- R3: Mode 3 places dataBusIn on aluBusOut[7:0] with aluLoDrvEn 1. Mode 4 places it on aluBusOut[15:8] with aluHiDrvEn 1. The other half has its enable at 0 and reads zero, and dataDrvEn is 0.
- R4: Mode 0 and the unused codes 5, 6 and 7 disconnect the buses. All three drive enables are 0 and dataBusOut and aluBusOut are zero.
- R5: When the latched ucAddrFromPc is 1, addrBus equals pcVal. When it is 0, addrBus equals marVal.
- R6: segData equals the latched ucDataSeg (1 = data segment, 0 = code segment).
- R7: memEnN equals the latched ucMemOff, so the memory is read (memEnN = 0) unless the word clears the enable.
- R8: devSel is nonzero only when segData is 1, memEnN is 0 and addrBus[15:8] equals the device page (default 0xFF). Then exactly one bit is set, and its index is addrBus[7:6] for the default four devices (64-byte slots).
- R9: With segData 0, devSel stays zero for every address, including device-page addresses.
- R10: A halt loop made of the three steps PC-to-ALU, idle word and fetch, with marVal left on a device address and no data segment requested, never raises any devSel bit.
- R11: A microcode word presented before a rising edge takes effect only after that edge. Outputs between edges reflect the word latched at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ucMode | input | 3 | Bridge mode field: 0 off, 1 ALU low to data, 2 ALU high to data, 3 data to ALU low, 4 data to ALU high |
| ucAddrFromPc | input | 1 | Pass the program counter through the address bus |
| ucDataSeg | input | 1 | Select the data segment (0 = code) |
| ucMemOff | input | 1 | Deassert the memory enable |
| pcVal | input | 16 | Program counter value |
| marVal | input | 16 | Memory address register value |
| aluBusIn | input | 16 | Value on the ALU bus |
| dataBusIn | input | 8 | Value on the memory data bus |
| aluBusOut | output | 16 | Value the bridge drives onto the ALU bus |
| aluLoDrvEn | output | 1 | Bridge drives ALU bus bits 7:0 |
| aluHiDrvEn | output | 1 | Bridge drives ALU bus bits 15:8 |
| dataBusOut | output | 8 | Value the bridge drives onto the data bus |
| dataDrvEn | output | 1 | Bridge drives the data bus |
| addrBus | output | 16 | Memory address bus |
| segData | output | 1 | Segment select, 1 = data |
| memEnN | output | 1 | Active-low memory enable |
| devSel | output | 4 | One-hot peripheral chip selects |

## Verification
Three functions can fall in one cycle: the address source, the memory enable and the peripheral decoder. A cycle that passes the program counter to the ALU is also an implicit memory read, so it can hit a device window. The bench provokes this in two ways. It runs a halt loop with the memory address register parked on a device address and the program counter on a device address, with the data segment never set. It also repeats the same addresses with the data segment set. A device select is accepted only in the second case, and only on the slot given by the address that is actually on the bus.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF        = 3'd0,
    MODE_LO_TO_DATA = 3'd1,
    MODE_HI_TO_DATA = 3'd2,
    MODE_DATA_TO_LO = 3'd3,
    MODE_DATA_TO_HI = 3'd4
  } bridge_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loToData;
    logic hiToData;
    logic dataToLo;
    logic dataToHi;
    logic addrFromPc;
    logic segData;
    logic memEn;
  } bridge_strobe_t;

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] ucMode,
  input  logic              ucAddrFromPc,
  input  logic              ucDataSeg,
  input  logic              ucMemOff,
  output bridge_strobe_t    strobe
);

  logic [MODE_W-1:0] uwMode;
  logic              uwAddrFromPc;
  logic              uwDataSeg;
  logic              uwMemOff;

  // microword register; reset loads the idle word (all fields zero)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uwMode       <= MODE_OFF;
      uwAddrFromPc <= 1'b0;
      uwDataSeg    <= 1'b0;
      uwMemOff     <= 1'b0;
    end else begin
      uwMode       <= ucMode;
      uwAddrFromPc <= ucAddrFromPc;
      uwDataSeg    <= ucDataSeg;
      uwMemOff     <= ucMemOff;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.addrFromPc = uwAddrFromPc;
    strobe.segData    = uwDataSeg;
    strobe.memEn      = !uwMemOff;
    case (uwMode)
      MODE_LO_TO_DATA: strobe.loToData = 1'b1;
      MODE_HI_TO_DATA: strobe.hiToData = 1'b1;
      MODE_DATA_TO_LO: strobe.dataToLo = 1'b1;
      MODE_DATA_TO_HI: strobe.dataToHi = 1'b1;
      default:         ; // off and unused codes leave the buses apart
    endcase
  end

endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          DEV_COUNT = 4,
  parameter int unsigned DEV_PAGE  = 255
) (
  input  bridge_strobe_t        strobe,
  input  logic [ADDR_W-1:0]     pcVal,
  input  logic [ADDR_W-1:0]     marVal,
  input  logic [2*DATA_W-1:0]   aluBusIn,
  input  logic [DATA_W-1:0]     dataBusIn,
  output logic [2*DATA_W-1:0]   aluBusOut,
  output logic                  aluLoDrvEn,
  output logic                  aluHiDrvEn,
  output logic [DATA_W-1:0]     dataBusOut,
  output logic                  dataDrvEn,
  output logic [ADDR_W-1:0]     addrBus,
  output logic                  segData,
  output logic                  memEnN,
  output logic [DEV_COUNT-1:0]  devSel
);

  localparam int PAGE_W    = ADDR_W - DATA_W;
  localparam int SLOT_BITS = (DEV_COUNT > 1) ? $clog2(DEV_COUNT) : 1;

  // byte lane steering
  always_comb begin
    dataBusOut = '0;
    if (strobe.loToData)      dataBusOut = aluBusIn[DATA_W-1:0];
    else if (strobe.hiToData) dataBusOut = aluBusIn[2*DATA_W-1:DATA_W];
  end

  assign dataDrvEn  = strobe.loToData | strobe.hiToData;
  assign aluLoDrvEn = strobe.dataToLo;
  assign aluHiDrvEn = strobe.dataToHi;
  assign aluBusOut  = {strobe.dataToHi ? dataBusIn : {DATA_W{1'b0}},
                       strobe.dataToLo ? dataBusIn : {DATA_W{1'b0}}};

  // address and memory control
  assign addrBus = strobe.addrFromPc ? pcVal : marVal;
  assign segData = strobe.segData;
  assign memEnN  = !strobe.memEn;

  // peripheral decoder, live only for enabled data-segment accesses
  logic inWindow;
  assign inWindow = strobe.segData && strobe.memEn &&
                    (addrBus[ADDR_W-1:DATA_W] == PAGE_W'(DEV_PAGE));

  generate
    if (DEV_COUNT == 1) begin : gSingle
      assign devSel = inWindow;
    end else begin : gMulti
      for (genvar g = 0; g < DEV_COUNT; g++) begin : gSlot
        assign devSel[g] = inWindow &&
          (addrBus[DATA_W-1 -: SLOT_BITS] == SLOT_BITS'(g));
      end
    end
  endgenerate

endmodule

// File: rtl/bridge_ctl_top.sv
module bridge_ctl_top
  import bridge_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          DEV_COUNT = 4,
  parameter int unsigned DEV_PAGE  = 255
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [MODE_W-1:0]     ucMode,
  input  logic                  ucAddrFromPc,
  input  logic                  ucDataSeg,
  input  logic                  ucMemOff,
  input  logic [ADDR_W-1:0]     pcVal,
  input  logic [ADDR_W-1:0]     marVal,
  input  logic [2*DATA_W-1:0]   aluBusIn,
  input  logic [DATA_W-1:0]     dataBusIn,
  output logic [2*DATA_W-1:0]   aluBusOut,
  output logic                  aluLoDrvEn,
  output logic                  aluHiDrvEn,
  output logic [DATA_W-1:0]     dataBusOut,
  output logic                  dataDrvEn,
  output logic [ADDR_W-1:0]     addrBus,
  output logic                  segData,
  output logic                  memEnN,
  output logic [DEV_COUNT-1:0]  devSel
);

  bridge_strobe_t strobe;

  bridge_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .ucMode       (ucMode),
    .ucAddrFromPc (ucAddrFromPc),
    .ucDataSeg    (ucDataSeg),
    .ucMemOff     (ucMemOff),
    .strobe       (strobe)
  );

  bridge_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DEV_COUNT (DEV_COUNT),
    .DEV_PAGE  (DEV_PAGE)
  ) uPath (
    .strobe     (strobe),
    .pcVal      (pcVal),
    .marVal     (marVal),
    .aluBusIn   (aluBusIn),
    .dataBusIn  (dataBusIn),
    .aluBusOut  (aluBusOut),
    .aluLoDrvEn (aluLoDrvEn),
    .aluHiDrvEn (aluHiDrvEn),
    .dataBusOut (dataBusOut),
    .dataDrvEn  (dataDrvEn),
    .addrBus    (addrBus),
    .segData    (segData),
    .memEnN     (memEnN),
    .devSel     (devSel)
  );

endmodule

// File: rtl/bridge_ctl_checker.sv
module bridge_ctl_checker #(
  parameter int ADDR_W    = 16,
  parameter int DEV_COUNT = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           ucMode,
  input logic                 ucAddrFromPc,
  input logic                 ucDataSeg,
  input logic                 ucMemOff,
  input logic [ADDR_W-1:0]    pcVal,
  input logic [ADDR_W-1:0]    marVal,
  input logic                 aluLoDrvEn,
  input logic                 aluHiDrvEn,
  input logic                 dataDrvEn,
  input logic [ADDR_W-1:0]    addrBus,
  input logic                 segData,
  input logic                 memEnN,
  input logic [DEV_COUNT-1:0] devSel
);

  assert_addr_pc_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ucAddrFromPc)) |-> (addrBus == pcVal));

  assert_addr_mar_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(ucAddrFromPc)) |-> (addrBus == marVal));

  assert_seg_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (segData == $past(ucDataSeg)));

  assert_memen_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (memEnN == $past(ucMemOff)));

  assert_dev_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devSel));

  assert_memoff_no_dev_R8: assert property (@(posedge clk) disable iff (!rstN)
    memEnN |-> (devSel == '0));

  assert_code_no_dev_R9: assert property (@(posedge clk) disable iff (!rstN)
    !segData |-> (devSel == '0));

  assert_data_drv_alone_R2: assert property (@(posedge clk) disable iff (!rstN)
    dataDrvEn |-> (!aluLoDrvEn && !aluHiDrvEn));

  assert_one_alu_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(aluLoDrvEn && aluHiDrvEn));

  assert_idle_apart_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(ucMode) == 3'd0 || $past(ucMode) > 3'd4))
      |-> (!dataDrvEn && !aluLoDrvEn && !aluHiDrvEn));

endmodule

bind bridge_ctl_top bridge_ctl_checker #(
  .ADDR_W    (ADDR_W),
  .DEV_COUNT (DEV_COUNT)
) uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .ucMode       (ucMode),
  .ucAddrFromPc (ucAddrFromPc),
  .ucDataSeg    (ucDataSeg),
  .ucMemOff     (ucMemOff),
  .pcVal        (pcVal),
  .marVal       (marVal),
  .aluLoDrvEn   (aluLoDrvEn),
  .aluHiDrvEn   (aluHiDrvEn),
  .dataDrvEn    (dataDrvEn),
  .addrBus      (addrBus),
  .segData      (segData),
  .memEnN       (memEnN),
  .devSel       (devSel)
);

// File: tb/bridge_ctl_top_test.sv
module bridge_ctl_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  ucMode = '0;
  logic        ucAddrFromPc = 1'b0;
  logic        ucDataSeg = 1'b0;
  logic        ucMemOff = 1'b0;
  logic [15:0] pcVal = '0;
  logic [15:0] marVal = '0;
  logic [15:0] aluBusIn = '0;
  logic [7:0]  dataBusIn = '0;
  logic [15:0] aluBusOut;
  logic        aluLoDrvEn, aluHiDrvEn, dataDrvEn, segData, memEnN;
  logic [7:0]  dataBusOut;
  logic [15:0] addrBus;
  logic [3:0]  devSel;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bridge_ctl_top uut (
    .clk(clk), .rstN(rstN), .ucMode(ucMode), .ucAddrFromPc(ucAddrFromPc),
    .ucDataSeg(ucDataSeg), .ucMemOff(ucMemOff), .pcVal(pcVal), .marVal(marVal),
    .aluBusIn(aluBusIn), .dataBusIn(dataBusIn), .aluBusOut(aluBusOut),
    .aluLoDrvEn(aluLoDrvEn), .aluHiDrvEn(aluHiDrvEn), .dataBusOut(dataBusOut),
    .dataDrvEn(dataDrvEn), .addrBus(addrBus), .segData(segData),
    .memEnN(memEnN), .devSel(devSel)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  mode;
    logic        pcSel;
    logic        dseg;
    logic        memOff;
    logic [15:0] pc;
    logic [15:0] mar;
    logic [15:0] alu;
    logic [7:0]  dat;
    logic [15:0] eAddr;
    logic [3:0]  eDev;
    logic        eDataEn;
    logic        eLo;
    logic        eHi;
    logic [7:0]  eDataOut;
    logic [15:0] eAluOut;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{8'd9, 3'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'hFF10, 16'h0000, 8'h00, 16'hFF10, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000}, // R9 code seg on device page
    '{8'd8, 3'd0, 1'b0, 1'b1, 1'b0, 16'h1234, 16'hFF10, 16'h0000, 8'h00, 16'hFF10, 4'b0001, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000}, // R8 slot 0
    '{8'd8, 3'd0, 1'b0, 1'b1, 1'b0, 16'h1234, 16'hFF45, 16'h0000, 8'h00, 16'hFF45, 4'b0010, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000}, // R8 slot 1
    '{8'd8, 3'd0, 1'b0, 1'b1, 1'b0, 16'h1234, 16'hFFC0, 16'h0000, 8'h00, 16'hFFC0, 4'b1000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000}, // R8 slot 3
    '{8'd7, 3'd0, 1'b0, 1'b1, 1'b1, 16'h1234, 16'hFF80, 16'h0000, 8'h00, 16'hFF80, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000}, // R7 enable off
    '{8'd8, 3'd0, 1'b0, 1'b1, 1'b0, 16'h1234, 16'hFE80, 16'h0000, 8'h00, 16'hFE80, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000}, // R8 outside page
    '{8'd2, 3'd1, 1'b0, 1'b1, 1'b0, 16'h1234, 16'h0100, 16'hA5C3, 8'h11, 16'h0100, 4'b0000, 1'b1, 1'b0, 1'b0, 8'hC3, 16'h0000}, // R2 low byte out
    '{8'd2, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1234, 16'h0100, 16'hA5C3, 8'h11, 16'h0100, 4'b0000, 1'b1, 1'b0, 1'b0, 8'hA5, 16'h0000}, // R2 high byte out
    '{8'd3, 3'd3, 1'b0, 1'b1, 1'b0, 16'h1234, 16'h0100, 16'hFFFF, 8'h7E, 16'h0100, 4'b0000, 1'b0, 1'b1, 1'b0, 8'h00, 16'h007E}, // R3 low byte in
    '{8'd3, 3'd4, 1'b0, 1'b1, 1'b0, 16'h1234, 16'h0100, 16'hFFFF, 8'h7E, 16'h0100, 4'b0000, 1'b0, 1'b0, 1'b1, 8'h00, 16'h7E00}, // R3 high byte in
    '{8'd4, 3'd6, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0100, 16'hFFFF, 8'hFF, 16'h0100, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000}, // R4 unused code
    '{8'd5, 3'd0, 1'b1, 1'b1, 1'b0, 16'hFF80, 16'h0010, 16'h0000, 8'h00, 16'hFF80, 4'b0100, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000}, // R5 PC on bus, data seg
    '{8'd5, 3'd0, 1'b1, 1'b0, 1'b0, 16'hFF80, 16'h0010, 16'h0000, 8'h00, 16'hFF80, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000}  // R5 PC on bus, code seg
  };

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setWord(logic [2:0] m, logic p, logic d, logic o);
    ucMode = m; ucAddrFromPc = p; ucDataSeg = d; ucMemOff = o;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    int hits;
    // R1: reset holds idle outputs despite a busy word at the inputs
    setWord(3'd1, 1'b1, 1'b1, 1'b1);
    pcVal = 16'hFF00; marVal = 16'hFF40; aluBusIn = 16'hBEEF; dataBusIn = 8'h5A;
    repeat (3) @(negedge clk);
    check("R1", "addrBus", 32'(addrBus), 32'hFF40);
    check("R1", "segData", 32'(segData), 32'd0);
    check("R1", "memEnN", 32'(memEnN), 32'd0);
    check("R1", "devSel", 32'(devSel), 32'd0);
    check("R1", "drive", 32'({dataDrvEn, aluLoDrvEn, aluHiDrvEn}), 32'd0);
    check("R1", "buses", 32'({dataBusOut, aluBusOut}), 32'd0);
    setWord(3'd0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // vector table: word set at one falling edge, checked at the next
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      setWord(VECS[i].mode, VECS[i].pcSel, VECS[i].dseg, VECS[i].memOff);
      pcVal = VECS[i].pc; marVal = VECS[i].mar;
      aluBusIn = VECS[i].alu; dataBusIn = VECS[i].dat;
      @(negedge clk);
      check(tag, "addrBus", 32'(addrBus), 32'(VECS[i].eAddr));
      check(tag, "devSel", 32'(devSel), 32'(VECS[i].eDev));
      check(tag, "dataDrvEn", 32'(dataDrvEn), 32'(VECS[i].eDataEn));
      check(tag, "aluLoDrvEn", 32'(aluLoDrvEn), 32'(VECS[i].eLo));
      check(tag, "aluHiDrvEn", 32'(aluHiDrvEn), 32'(VECS[i].eHi));
      check(tag, "dataBusOut", 32'(dataBusOut), 32'(VECS[i].eDataOut));
      check(tag, "aluBusOut", 32'(aluBusOut), 32'(VECS[i].eAluOut));
      check("R6", "segData", 32'(segData), 32'(VECS[i].dseg));
      check("R7", "memEnN", 32'(memEnN), 32'(VECS[i].memOff));
    end

    // R11: a new word is not visible before the rising edge
    setWord(3'd0, 1'b0, 1'b0, 1'b0);
    marVal = 16'hFF00;
    @(negedge clk);
    setWord(3'd1, 1'b0, 1'b1, 1'b0);
    aluBusIn = 16'h0042;
    #1;
    check("R11", "segData before edge", 32'(segData), 32'd0);
    check("R11", "dataDrvEn before edge", 32'(dataDrvEn), 32'd0);
    check("R11", "devSel before edge", 32'(devSel), 32'd0);
    @(negedge clk);
    check("R11", "segData after edge", 32'(segData), 32'd1);
    check("R11", "dataBusOut after edge", 32'(dataBusOut), 32'h42);
    check("R11", "devSel after edge", 32'(devSel), 32'b0001);

    // R10: halt loop with MAR parked on a device and PC on the device page
    marVal = 16'hFF00; pcVal = 16'hFFC4; aluBusIn = 16'h0; hits = 0;
    for (int k = 0; k < 8; k++) begin
      setWord(3'd0, 1'b1, 1'b0, 1'b0);   // PC passed to ALU
      @(negedge clk);
      if (devSel != 0) hits++;
      check("R5", "halt step PC addr", 32'(addrBus), 32'hFFC4);
      setWord(3'd0, 1'b0, 1'b0, 1'b0);   // idle word: MAR on bus
      @(negedge clk);
      if (devSel != 0) hits++;
      check("R5", "halt step MAR addr", 32'(addrBus), 32'hFF00);
      check("R10", "halt step idle memEnN", 32'(memEnN), 32'd0);
      setWord(3'd0, 1'b1, 1'b0, 1'b0);   // fetch
      @(negedge clk);
      if (devSel != 0) hits++;
    end
    check("R10", "device selects during halt loop", 32'(hits), 32'd0);

    // same addresses with the data segment explicitly requested
    setWord(3'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check("R8", "explicit data read via PC", 32'(devSel), 32'b1000);
    setWord(3'd0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R8", "explicit data read via MAR", 32'(devSel), 32'b0001);

    // R1: reset re-asserted mid-run returns to idle
    rstN = 1'b0;
    #1;
    check("R1", "segData in reset", 32'(segData), 32'd0);
    check("R1", "devSel in reset", 32'(devSel), 32'd0);
    finish();
  end

endmodule